// File: doc/BRIEF.md
# Reel sprite renderer

This block colours the pixels of three slot-machine reel windows on a raster display. Each clock it receives the horizontal and vertical coordinate of the pixel being scanned, the three timing strobes of that pixel, and one scroll offset per reel. It finds which reel window, if any, holds the pixel. It works out the pixel's position on that reel's vertical strip of sprites and which sprite lies there. From that it forms a read address into a sprite store that is split into banks, and returns a 3-bit colour after a fixed pipeline delay. The timing strobes are delayed by the same amount, so colour and timing stay aligned at the display interface.

Sprites are held at 64x64 and drawn at 128x128 by repeating every source pixel twice in each direction. The halved local coordinates form a 12-bit source index. Its top two bits pick one of four 1024-word banks, and its low ten bits are the word address sent to every bank. All 28 banks (7 sprites times 4 banks) are read in parallel by an external store with one cycle of read latency. Their outputs pass through two registered multiplexer levels: one picks the bank inside each sprite, the next picks the sprite. This keeps the fan-in of any one register to a handful of inputs.

Each reel shows a strip of the 7 sprites, stacked top to bottom, 896 display rows long, which wraps around. The reel offset shifts the strip under a fixed window. Reel r starts its strip two sprites further along than reel r-1.

Top module: `reel_sprite_renderer`

## Requirements
- R1: Reel r (r = 0, 1, 2) owns the pixels with horizontal coordinate 64+192r through 64+192r+127 and vertical coordinate 176 through 303. Every other pixel comes out black (colour 0).
- R2: A pixel presented with the active-video input low comes out black, whatever its coordinates.
- R3: Inside a window, with local coordinates lx = h - (64+192r) and strip-local row ly (see R4), the source index is (ly/2)*64 + lx/2. Bits 11:10 of that index select the bank, and bits 9:0 are driven on `rom_addr`. Hence each 2x2 block of display pixels shows one stored pixel.
- R4: For a pixel in reel r's window, the strip row is ((v - 176) + offset_r) mod 896 for any offset 0 to 1023. The strip-local row is strip row mod 128. The sprite index is (strip row / 128 + 2r) mod 7.
- R5: `rom_data` carries 28 three-bit bank outputs. Bank b of sprite s occupies bits 3k+2:3k with k = 4s + b. The colour returned is the selected bank's word read at the address of the cycle before, with bit 2 red, bit 1 green and bit 0 blue.
- R6: The colour of a pixel appears on `rgb_out` four rising clock edges after its coordinates are presented. A new pixel can be presented every cycle.
- R7: `hsync_out`, `vsync_out` and `de_out` repeat `hsync_in`, `vsync_in` and `de_in` exactly four rising edges later.
- R8: While `rst_n` is low, `rgb_out`, `rom_addr` and the three delayed strobes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos_in | input | 10 | Horizontal coordinate of the current pixel |
| vpos_in | input | 10 | Vertical coordinate of the current pixel |
| hsync_in | input | 1 | Horizontal sync for the current pixel |
| vsync_in | input | 1 | Vertical sync for the current pixel |
| de_in | input | 1 | Active-video strobe for the current pixel |
| reel_offset | input | 30 | Scroll offsets, reel r in bits 10r+9:10r |
| rom_addr | output | 10 | Word address broadcast to all sprite banks |
| rom_data | input | 84 | Registered read data of all 28 banks |
| rgb_out | output | 3 | Pixel colour (red, green, blue) |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |
| de_out | output | 1 | Delayed active-video strobe |

## Verification
Each internal fault shows up in the colour stream within the four-cycle latency. A wrong window decode or strip wrap makes a sprite appear shifted, split at the wrong row, or bleeding into the black margins. A wrong bank or sprite select shows the texture of a neighbouring bank or sprite, so the test store gives every sprite, bank, source row and source column its own colour pattern. A pipeline stage too many or too few on either path shifts every colour by one pixel against the strobes. Running a scan line through the pixel-by-pixel stream exposes this on the first edge of a window.

// File: rtl/reel_render_pkg.sv
package reel_render_pkg;
  localparam int PIX_W = 3;
  typedef logic [PIX_W-1:0] rgb_t;
  localparam rgb_t RGB_BLACK = '0;
endpackage

// File: rtl/reel_locator.sv
module reel_locator #(
  parameter int CW         = 10,
  parameter int OFF_W      = 10,
  parameter int N_REELS    = 3,
  parameter int N_SPRITES  = 7,
  parameter int N_BANKS    = 4,
  parameter int SRC_DIM    = 64,
  parameter int WIN_X0     = 64,
  parameter int WIN_PITCH  = 192,
  parameter int WIN_Y0     = 176,
  parameter int STRIP_STEP = 2,
  localparam int SRC_LOG   = $clog2(SRC_DIM),
  localparam int DISP_LOG  = SRC_LOG + 1,
  localparam int ADDR_W    = 2 * SRC_LOG,
  localparam int BANK_LOG  = $clog2(N_BANKS),
  localparam int WORD_W    = ADDR_W - BANK_LOG,
  localparam int SPR_W     = $clog2(N_SPRITES),
  localparam int RW        = OFF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            hpos,
  input  logic [CW-1:0]            vpos,
  input  logic                     de,
  input  logic [N_REELS*OFF_W-1:0] offsets,
  output logic [N_REELS-1:0]       reel_hit,
  output logic [RW-1:0]            strip_row,
  output logic                     hit_q,
  output logic [SPR_W-1:0]         sprite_q,
  output logic [BANK_LOG-1:0]      bank_q,
  output logic [WORD_W-1:0]        word_q
);
  localparam int DISP_DIM = 2 * SRC_DIM;
  localparam int REEL_W   = (N_REELS > 1) ? $clog2(N_REELS) : 1;
  localparam logic [RW-1:0] STRIP_ROWS = RW'(N_SPRITES * DISP_DIM);
  localparam logic [CW:0]   YLO = (CW+1)'(WIN_Y0);
  localparam logic [CW:0]   YHI = (CW+1)'(WIN_Y0 + DISP_DIM);

  // One conditional subtraction wraps any offset below 2*STRIP_ROWS - DISP_DIM.
  function automatic logic [RW-1:0] wrap_strip(input logic [RW-1:0] sum);
    return (sum >= STRIP_ROWS) ? sum - STRIP_ROWS : sum;
  endfunction

  // Pixel doubling: two display pixels per source pixel.
  function automatic logic [SRC_LOG-1:0] halve(input logic [DISP_LOG-1:0] d);
    return SRC_LOG'(d >> 1);
  endfunction

  function automatic logic [ADDR_W-1:0] src_index(input logic [SRC_LOG-1:0] yh,
                                                  input logic [SRC_LOG-1:0] xh);
    return {yh, xh};
  endfunction

  function automatic logic [SPR_W-1:0] strip_sprite(input logic [SPR_W-1:0]  band,
                                                    input logic [REEL_W-1:0] reel);
    int t;
    t = int'(band) + STRIP_STEP * int'(reel);
    return SPR_W'(t % N_SPRITES);
  endfunction

  logic                y_in;
  logic [DISP_LOG-1:0] ly;
  logic [DISP_LOG-1:0] lx_arr [N_REELS];

  assign y_in = ({1'b0, vpos} >= YLO) && ({1'b0, vpos} < YHI);
  assign ly   = DISP_LOG'({1'b0, vpos} - YLO);

  for (genvar r = 0; r < N_REELS; r++) begin : g_reel
    localparam logic [CW:0] XLO = (CW+1)'(WIN_X0 + r * WIN_PITCH);
    localparam logic [CW:0] XHI = (CW+1)'(WIN_X0 + r * WIN_PITCH + DISP_DIM);
    assign reel_hit[r] = y_in && ({1'b0, hpos} >= XLO) && ({1'b0, hpos} < XHI);
    assign lx_arr[r]   = DISP_LOG'({1'b0, hpos} - XLO);
  end

  logic [REEL_W-1:0]   sel_reel;
  logic [DISP_LOG-1:0] sel_lx;
  logic [OFF_W-1:0]    sel_off;

  always_comb begin
    sel_reel = '0;
    sel_lx   = '0;
    sel_off  = '0;
    for (int r = 0; r < N_REELS; r++) begin
      if (reel_hit[r]) begin
        sel_reel = REEL_W'(r);
        sel_lx   = lx_arr[r];
        sel_off  = offsets[r*OFF_W +: OFF_W];
      end
    end
  end

  logic [SPR_W-1:0]    band;
  logic [DISP_LOG-1:0] row_local;
  logic [ADDR_W-1:0]   addr;

  assign strip_row = wrap_strip(RW'(ly) + RW'(sel_off));
  assign band      = strip_row[DISP_LOG +: SPR_W];
  assign row_local = strip_row[DISP_LOG-1:0];
  assign addr      = src_index(halve(row_local), halve(sel_lx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      sprite_q <= '0;
      bank_q   <= '0;
      word_q   <= '0;
    end else begin
      hit_q    <= de && (|reel_hit);
      sprite_q <= strip_sprite(band, sel_reel);
      bank_q   <= addr[ADDR_W-1 -: BANK_LOG];
      word_q   <= addr[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/pixel_delay.sv
module pixel_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[i] <= '0;
        else        pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[i] <= '0;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/bank_mux_stage.sv
module bank_mux_stage
  import reel_render_pkg::*;
#(
  parameter int N_SPRITES = 7,
  parameter int N_BANKS   = 4,
  localparam int BANK_LOG = $clog2(N_BANKS),
  localparam int DATA_W   = PIX_W * N_SPRITES * N_BANKS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DATA_W-1:0]          rom_data,
  input  logic [BANK_LOG-1:0]        bank_sel,
  output logic [N_SPRITES*PIX_W-1:0] col_q
);
  rgb_t col_arr [N_SPRITES];

  // First level: one narrow bank multiplexer per sprite, registered.
  for (genvar s = 0; s < N_SPRITES; s++) begin : g_spr
    rgb_t pick;
    always_comb begin
      pick = RGB_BLACK;
      for (int b = 0; b < N_BANKS; b++) begin
        if (bank_sel == BANK_LOG'(b)) pick = rom_data[(s*N_BANKS + b)*PIX_W +: PIX_W];
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) col_arr[s] <= RGB_BLACK;
      else        col_arr[s] <= pick;
    end
    assign col_q[s*PIX_W +: PIX_W] = col_arr[s];
  end
endmodule

// File: rtl/sprite_mux_stage.sv
module sprite_mux_stage
  import reel_render_pkg::*;
#(
  parameter int N_SPRITES = 7,
  localparam int SPR_W    = $clog2(N_SPRITES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SPRITES*PIX_W-1:0] col_in,
  input  logic [SPR_W-1:0]           sprite_sel,
  input  logic                       hit,
  output rgb_t                       rgb_q
);
  rgb_t pick;

  // Second level: sprite select, with the window/blank gate folded in.
  always_comb begin
    pick = RGB_BLACK;
    for (int s = 0; s < N_SPRITES; s++) begin
      if (hit && sprite_sel == SPR_W'(s)) pick = col_in[s*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_q <= RGB_BLACK;
    else        rgb_q <= pick;
  end
endmodule

// File: rtl/reel_sprite_renderer.sv
module reel_sprite_renderer
  import reel_render_pkg::*;
#(
  parameter int CW         = 10,
  parameter int OFF_W      = 10,
  parameter int N_REELS    = 3,
  parameter int N_SPRITES  = 7,
  parameter int N_BANKS    = 4,
  parameter int SRC_DIM    = 64,
  parameter int WIN_X0     = 64,
  parameter int WIN_PITCH  = 192,
  parameter int WIN_Y0     = 176,
  parameter int STRIP_STEP = 2,
  localparam int SRC_LOG   = $clog2(SRC_DIM),
  localparam int BANK_LOG  = $clog2(N_BANKS),
  localparam int WORD_W    = 2 * SRC_LOG - BANK_LOG,
  localparam int DATA_W    = PIX_W * N_SPRITES * N_BANKS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            hpos_in,
  input  logic [CW-1:0]            vpos_in,
  input  logic                     hsync_in,
  input  logic                     vsync_in,
  input  logic                     de_in,
  input  logic [N_REELS*OFF_W-1:0] reel_offset,
  output logic [WORD_W-1:0]        rom_addr,
  input  logic [DATA_W-1:0]        rom_data,
  output logic [PIX_W-1:0]         rgb_out,
  output logic                     hsync_out,
  output logic                     vsync_out,
  output logic                     de_out
);
  localparam int SPR_W = $clog2(N_SPRITES);
  localparam int RW    = OFF_W + 1;
  // locator + store read + bank level + sprite level
  localparam int LAT   = 4;

  logic [N_REELS-1:0]  reel_hit;
  logic [RW-1:0]       strip_row;
  logic                s1_hit;
  logic [SPR_W-1:0]    s1_spr;
  logic [BANK_LOG-1:0] s1_bank;

  reel_locator #(
    .CW(CW), .OFF_W(OFF_W), .N_REELS(N_REELS), .N_SPRITES(N_SPRITES),
    .N_BANKS(N_BANKS), .SRC_DIM(SRC_DIM), .WIN_X0(WIN_X0),
    .WIN_PITCH(WIN_PITCH), .WIN_Y0(WIN_Y0), .STRIP_STEP(STRIP_STEP)
  ) u_loc (
    .clk(clk), .rst_n(rst_n), .hpos(hpos_in), .vpos(vpos_in), .de(de_in),
    .offsets(reel_offset), .reel_hit(reel_hit), .strip_row(strip_row),
    .hit_q(s1_hit), .sprite_q(s1_spr), .bank_q(s1_bank), .word_q(rom_addr)
  );

  // Stage 2: side information waits one cycle for the store read.
  logic                p2_hit;
  logic [SPR_W-1:0]    p2_spr;
  logic [BANK_LOG-1:0] p2_bank;

  pixel_delay #(.W(1 + SPR_W + BANK_LOG), .DEPTH(1)) u_meta2 (
    .clk(clk), .rst_n(rst_n),
    .d({s1_hit, s1_spr, s1_bank}), .q({p2_hit, p2_spr, p2_bank})
  );

  logic [N_SPRITES*PIX_W-1:0] sprite_cols;

  bank_mux_stage #(.N_SPRITES(N_SPRITES), .N_BANKS(N_BANKS)) u_bank (
    .clk(clk), .rst_n(rst_n), .rom_data(rom_data), .bank_sel(p2_bank),
    .col_q(sprite_cols)
  );

  // Stage 3: sprite select and hit follow the bank level.
  logic             p3_hit;
  logic [SPR_W-1:0] p3_spr;

  pixel_delay #(.W(1 + SPR_W), .DEPTH(1)) u_meta3 (
    .clk(clk), .rst_n(rst_n), .d({p2_hit, p2_spr}), .q({p3_hit, p3_spr})
  );

  sprite_mux_stage #(.N_SPRITES(N_SPRITES)) u_spr (
    .clk(clk), .rst_n(rst_n), .col_in(sprite_cols), .sprite_sel(p3_spr),
    .hit(p3_hit), .rgb_q(rgb_out)
  );

  // Timing strobes travel the same number of stages as the colour.
  pixel_delay #(.W(3), .DEPTH(LAT)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hsync_in, vsync_in, de_in}), .q({hsync_out, vsync_out, de_out})
  );
endmodule

// File: rtl/reel_render_checker.sv
module reel_render_checker #(
  parameter int N_REELS    = 3,
  parameter int RW         = 11,
  parameter int STRIP_ROWS = 896
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hsync_in,
  input logic               vsync_in,
  input logic               de_in,
  input logic               hsync_out,
  input logic               vsync_out,
  input logic               de_out,
  input logic [2:0]         rgb_out,
  input logic [N_REELS-1:0] reel_hit,
  input logic [RW-1:0]      strip_row,
  input logic               s1_hit
);
  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)             warm <= '0;
    else if (warm < 3'd4)   warm <= warm + 3'd1;
  end

  // R1: windows never overlap
  a_r1_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reel_hit));

  // R4: strip row always wrapped into the strip
  a_r4_row_wrapped: assert property (@(posedge clk) disable iff (!rst_n)
    strip_row < RW'(STRIP_ROWS));

  // R2: blanked pixels are black
  a_r2_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> rgb_out == 3'd0);

  // R1: a miss at the locator is black three edges later
  a_r1_miss_black: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_hit |-> ##3 rgb_out == 3'd0);

  // R7: strobes delayed by exactly four edges
  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    warm >= 3'd4 |-> (hsync_out == $past(hsync_in, 4)) &&
                     (vsync_out == $past(vsync_in, 4)) &&
                     (de_out    == $past(de_in, 4)));
endmodule

bind reel_sprite_renderer reel_render_checker #(
  .N_REELS(N_REELS), .RW(RW), .STRIP_ROWS(N_SPRITES * 2 * SRC_DIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
  .de_in(de_in), .hsync_out(hsync_out), .vsync_out(vsync_out),
  .de_out(de_out), .rgb_out(rgb_out), .reel_hit(reel_hit),
  .strip_row(strip_row), .s1_hit(s1_hit)
);

// File: tb/tb_reel_sprite_renderer.sv
module tb_reel_sprite_renderer;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  hpos_in = '0, vpos_in = '0;
  logic        hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
  logic [9:0]  off0 = '0, off1 = '0, off2 = '0;
  logic [29:0] reel_offset;
  logic [9:0]  rom_addr;
  logic [83:0] rom_data;
  logic [2:0]  rgb_out;
  logic        hsync_out, vsync_out, de_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign reel_offset = {off2, off1, off0};

  reel_sprite_renderer dut (
    .clk(clk), .rst_n(rst_n), .hpos_in(hpos_in), .vpos_in(vpos_in),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in),
    .reel_offset(reel_offset), .rom_addr(rom_addr), .rom_data(rom_data),
    .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .de_out(de_out)
  );

  // Test store: every sprite, bank, source row and column gets its own pattern.
  function automatic int rom_word(int s, int a);
    return (s*3 + a%64 + (a/64)*5 + (a/1024)*3 + 1) % 8;
  endfunction

  logic [2:0] bank_q [NBANK];
  always @(posedge clk) begin
    for (int k = 0; k < NBANK; k++) bank_q[k] <= 3'(rom_word(k/4, (k%4)*1024 + int'(rom_addr)));
  end
  always_comb begin
    for (int k = 0; k < NBANK; k++) rom_data[k*3 +: 3] = bank_q[k];
  end

  // Reference model restated from the requirements.
  function automatic int ref_reel(int h, int v);
    if (v < 176 || v > 303) return -1;
    for (int r = 0; r < 3; r++) if (h >= 64 + 192*r && h <= 191 + 192*r) return r;
    return -1;
  endfunction

  function automatic int ref_colour(int h, int v, bit de, int o0, int o1, int o2, int spr);
    int r, off, row, lx, ly;
    r = ref_reel(h, v);
    if (!de || r < 0) return 0;
    off = (r == 0) ? o0 : (r == 1) ? o1 : o2;
    row = ((v - 176) + off) % 896;
    if (spr < 0) spr = (row/128 + 2*r) % 7;
    lx = h - (64 + 192*r);
    ly = row % 128;
    return rom_word(spr, (ly/2)*64 + lx/2);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [9:0] h; logic [9:0] v; logic de;
    logic [9:0] o0; logic [9:0] o1; logic [9:0] o2;
    logic [2:0] spr;   // expected sprite, 7 = none
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{10'd64,  10'd176, 1'b1, 10'd0,   10'd0,    10'd0,   3'd0},
    '{10'd300, 10'd303, 1'b1, 10'd0,   10'd0,    10'd0,   3'd2},
    '{10'd500, 10'd200, 1'b1, 10'd0,   10'd0,    10'd128, 3'd5},
    '{10'd63,  10'd200, 1'b1, 10'd0,   10'd0,    10'd0,   3'd7},
    '{10'd192, 10'd200, 1'b1, 10'd0,   10'd0,    10'd0,   3'd7},
    '{10'd100, 10'd175, 1'b1, 10'd0,   10'd0,    10'd0,   3'd7},
    '{10'd100, 10'd304, 1'b1, 10'd0,   10'd0,    10'd0,   3'd7},
    '{10'd100, 10'd200, 1'b0, 10'd0,   10'd0,    10'd0,   3'd7},
    '{10'd100, 10'd303, 1'b1, 10'd895, 10'd0,    10'd0,   3'd0},
    '{10'd100, 10'd176, 1'b1, 10'd896, 10'd0,    10'd0,   3'd0},
    '{10'd383, 10'd250, 1'b1, 10'd0,   10'd1023, 10'd0,   3'd3},
    '{10'd575, 10'd176, 1'b1, 10'd0,   10'd0,    10'd768, 3'd3},
    '{10'd448, 10'd240, 1'b1, 10'd0,   10'd0,    10'd700, 3'd2}
  };

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int hist [160];

  initial begin
    // R8: reset state with live-looking inputs
    hpos_in = 10'd64; vpos_in = 10'd176; de_in = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 rgb in reset", int'(rgb_out), 0);
    chk("R8 rom_addr in reset", int'(rom_addr), 0);
    chk("R8 strobes in reset", int'({hsync_out, vsync_out, de_out}), 0);
    hsync_in = 1'b0; vsync_in = 1'b0; de_in = 1'b0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      hpos_in = VECS[i].h; vpos_in = VECS[i].v; de_in = VECS[i].de;
      off0 = VECS[i].o0; off1 = VECS[i].o1; off2 = VECS[i].o2;
      repeat (6) @(negedge clk);
      chk((VECS[i].spr == 3'd7) ? "R1 R2 black outside" : "R3 R4 R5 sprite pixel",
          int'(rgb_out),
          ref_colour(VECS[i].h, VECS[i].v, VECS[i].de, VECS[i].o0, VECS[i].o1,
                     VECS[i].o2, (VECS[i].spr == 3'd7) ? 0 : int'(VECS[i].spr)));
    end

    // R6: exact latency on the first pixel of a window
    off0 = '0; off1 = '0; off2 = '0; de_in = 1'b1;
    hpos_in = 10'd63; vpos_in = 10'd176;
    repeat (6) @(negedge clk);
    hpos_in = 10'd64;
    repeat (3) @(negedge clk);
    chk("R6 colour not yet at edge 3", int'(rgb_out), 0);
    @(negedge clk);
    chk("R6 colour at edge 4", int'(rgb_out), ref_colour(64, 176, 1'b1, 0, 0, 0, 0));

    // R7: strobes arrive exactly four edges later
    de_in = 1'b0; hpos_in = 10'd0;
    repeat (6) @(negedge clk);
    hsync_in = 1'b1; vsync_in = 1'b1; de_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 strobes at edge 3", int'({hsync_out, vsync_out, de_out}), 0);
    @(negedge clk);
    chk("R7 strobes at edge 4", int'({hsync_out, vsync_out, de_out}), 7);
    hsync_in = 1'b0; vsync_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 strobes fall", int'({hsync_out, vsync_out}), 0);

    // R3 R4 R6: scan line streamed one pixel per cycle across reel 0
    off0 = 10'd300; de_in = 1'b1; vpos_in = 10'd230;
    for (int i = 0; i < 154; i++) begin
      @(negedge clk);
      if (i >= 4) chk("R3 R6 stream", int'(rgb_out),
                      ref_colour(hist[i-4], 230, 1'b1, 300, 0, 0, -1));
      if (i < 150) begin
        hist[i] = 56 + i;
        hpos_in = 10'(56 + i);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule